// File: doc/BRIEF.md
# Secondary Cascaded Interrupt Controller

This block collects 32 level-sensitive interrupt sources behind a primary vectored controller. Each source is captured in an input register, gated by a per-source enable, and the gated result can be read back as a status word. Enables are never written directly. One register sets enable bits and another clears them, so a handler can mask or acknowledge one source without a read-modify-write sequence.

The enabled, active sources in the low group (0 to 8) are ORed into a single cascade line. That line feeds one input of the primary controller. Sources in the high group (21 to 31) can bypass the cascade: when a source's routing bit is set, its latched level goes to the primary input with the same number on a direct output. The secondary enable does not gate this path, because the primary controller does its own masking.

Software reaches the block through a small word-addressed register bus with address, write data, write strobe and combinational read data. Vector prioritisation belongs to the primary controller and is not part of this block.

Top module: `secint_ctrl`

## Requirements
- R1: After reset the enable and routing registers read 0, the status register reads 0, `cascade_o` is 0 and `direct_o` is 0.
- R2: A write to the enable-set register (byte offset 0x08) sets every enable bit written as 1 and leaves every bit written as 0 unchanged. A read of offset 0x08 returns the current enables.
- R3: A write to the enable-clear register (offset 0x0C) clears every enable bit written as 1 and leaves every bit written as 0 unchanged.
- R4: Sources are sampled into the input register on each clock edge. The raw register (offset 0x04) returns the sampled sources unmasked. The status register (offset 0x00) returns the sampled sources ANDed with their enables.
- R5: `cascade_o` is 1 exactly when some source in 0..8 is sampled active, enabled, and not routed. Source 8 is included.
- R6: Enabled, active sources 9..31 never drive `cascade_o`.
- R7: The routing register (offset 0x20) stores bits 21..31 only. Bits 0..20 read as 0 and ignore writes, so writing 0xFFD00000 reads back 0xFFC00000.
- R8: For i in 21..31, `direct_o[i]` is the sampled source i ANDed with routing bit i, independent of the enables. Bits 0..20 of `direct_o` are always 0.
- R9: Clearing a source's enable while the source stays active drops its status bit and its cascade contribution on the next cycle. The raw register still shows the source.
- R10: Writes to unmapped offsets change no register. Reads of unmapped offsets and of the enable-clear offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_addr_i | input | 6 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_wen_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| cascade_o | output | 1 | Shared line to the primary controller |
| direct_o | output | 32 | Direct lines to the same-numbered primary inputs |

## Verification
The hardest state to reach is one where a source is active at its pin but absent from status and cascade. This happens when a routing word contains non-storable bits, or when a source is acknowledged while its level persists. The vector table reaches these states by rewriting the enables and routes from a cleared state for each vector, so every entry starts from known registers. It includes a routing write of 0xFFD00000 that holds sources 20 and 21 active while neither can leave the block. A directed sequence then clears the enable of a held source and checks status, cascade and raw readback one cycle later.

// File: rtl/secint_pkg.sv
package secint_pkg;
  localparam int DW = 32;
  localparam int AW = 6;

  localparam logic [AW-1:0] OFS_STATUS = 6'h00;
  localparam logic [AW-1:0] OFS_RAW    = 6'h04;
  localparam logic [AW-1:0] OFS_ENSET  = 6'h08;
  localparam logic [AW-1:0] OFS_ENCLR  = 6'h0C;
  localparam logic [AW-1:0] OFS_ROUTE  = 6'h20;

  // Contiguous mask of bits lo..hi inclusive
  function automatic logic [DW-1:0] span_mask(input int lo, input int hi);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  // Enable register update: set ones, then clear ones
  function automatic logic [DW-1:0] next_enable(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] set_m,
                                                input logic [DW-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // Pending word seen by the cascade after routing is taken out
  function automatic logic [DW-1:0] cascade_pending(input logic [DW-1:0] gated,
                                                    input logic [DW-1:0] route,
                                                    input logic [DW-1:0] group);
    return gated & group & ~route;
  endfunction
endpackage

// File: rtl/secint_input_latch.sv
module secint_input_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] raw_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_o <= '0;
    else        raw_o <= src_i;
  end
endmodule

// File: rtl/secint_mask_regs.sv
module secint_mask_regs
  import secint_pkg::*;
#(
  parameter int          W          = 32,
  parameter logic [W-1:0] ROUTE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic         wr_route_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] route_o
);
  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;

  assign set_m = wr_set_i ? wdata_i : '0;
  assign clr_m = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_o <= '0;
    else        enable_o <= next_enable(enable_o, set_m, clr_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          route_o <= '0;
    else if (wr_route_i) route_o <= wdata_i & ROUTE_MASK;
  end
endmodule

// File: rtl/secint_fanout.sv
module secint_fanout
  import secint_pkg::*;
#(
  parameter int           W          = 32,
  parameter logic [W-1:0] CASC_MASK  = '0,
  parameter logic [W-1:0] ROUTE_MASK = '0
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] enable_i,
  input  logic [W-1:0] route_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] casc_pend_o,
  output logic         cascade_o,
  output logic [W-1:0] direct_o
);
  assign status_o    = raw_i & enable_i;
  assign casc_pend_o = cascade_pending(status_o, route_i, CASC_MASK);
  assign cascade_o   = |casc_pend_o;

  for (genvar i = 0; i < W; i++) begin : g_direct
    if (ROUTE_MASK[i]) begin : g_routable
      assign direct_o[i] = raw_i[i] & route_i[i];
    end else begin : g_fixed
      assign direct_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/secint_ctrl.sv
module secint_ctrl
  import secint_pkg::*;
#(
  parameter int CASC_LO  = 0,
  parameter int CASC_HI  = 8,
  parameter int ROUTE_LO = 21,
  parameter int ROUTE_HI = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_wen_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          cascade_o,
  output logic [DW-1:0] direct_o
);
  localparam logic [DW-1:0] CASC_MASK  = span_mask(CASC_LO, CASC_HI);
  localparam logic [DW-1:0] ROUTE_MASK = span_mask(ROUTE_LO, ROUTE_HI);

  logic [DW-1:0] raw_q;
  logic [DW-1:0] en_q;
  logic [DW-1:0] route_q;
  logic [DW-1:0] status_w;
  logic [DW-1:0] casc_pend_w;
  logic          wr_set_hit;
  logic          wr_clr_hit;
  logic          wr_route_hit;

  assign wr_set_hit   = bus_wen_i && (bus_addr_i == OFS_ENSET);
  assign wr_clr_hit   = bus_wen_i && (bus_addr_i == OFS_ENCLR);
  assign wr_route_hit = bus_wen_i && (bus_addr_i == OFS_ROUTE);

  secint_input_latch #(.W(DW)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .raw_o (raw_q)
  );

  secint_mask_regs #(.W(DW), .ROUTE_MASK(ROUTE_MASK)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_set_i   (wr_set_hit),
    .wr_clr_i   (wr_clr_hit),
    .wr_route_i (wr_route_hit),
    .wdata_i    (bus_wdata_i),
    .enable_o   (en_q),
    .route_o    (route_q)
  );

  secint_fanout #(.W(DW), .CASC_MASK(CASC_MASK), .ROUTE_MASK(ROUTE_MASK)) u_fan (
    .raw_i       (raw_q),
    .enable_i    (en_q),
    .route_i     (route_q),
    .status_o    (status_w),
    .casc_pend_o (casc_pend_w),
    .cascade_o   (cascade_o),
    .direct_o    (direct_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_STATUS: bus_rdata_o = status_w;
      OFS_RAW:    bus_rdata_o = raw_q;
      OFS_ENSET:  bus_rdata_o = en_q;
      OFS_ROUTE:  bus_rdata_o = route_q;
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/secint_checker.sv
module secint_checker
  import secint_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wen_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [DW-1:0] raw_q,
  input logic [DW-1:0] en_q,
  input logic [DW-1:0] route_q,
  input logic          cascade_o,
  input logic [DW-1:0] direct_o
);
  logic set_wr, clr_wr;
  assign set_wr = bus_wen_i && bus_addr_i == OFS_ENSET;
  assign clr_wr = bus_wen_i && bus_addr_i == OFS_ENCLR;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en_q & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en_q & $past(bus_wdata_i)) == '0)); // R3
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(en_q)); // R10
  AST_CASC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_o |-> ((raw_q & en_q & 32'h0000_01FF) != '0)); // R5
  AST_DIRECT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_o & ~(route_q & raw_q)) == '0); // R8
  AST_ROUTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    route_q[20:0] == '0); // R7
endmodule

bind secint_ctrl secint_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wen_i   (bus_wen_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .raw_q       (raw_q),
  .en_q        (en_q),
  .route_q     (route_q),
  .cascade_o   (cascade_o),
  .direct_o    (direct_o)
);

// File: tb/secint_ctrl_bench.sv
module secint_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic [31:0] rdata;
  logic        casc;
  logic [31:0] dir;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  secint_ctrl u_secint_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_wen_i(wen), .bus_rdata_o(rdata),
    .cascade_o(casc), .direct_o(dir)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] route;
    logic [31:0] src;
    logic [31:0] status;
    logic        casc;
    logic [31:0] dir;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{32'h0000_01FF, 32'h0,         32'h0000_0001, 32'h0000_0001, 1'b1, 32'h0},          // R5
    '{32'h0000_01FF, 32'h0,         32'h0000_0200, 32'h0,         1'b0, 32'h0},          // R4
    '{32'hFFFF_FFFF, 32'h0,         32'h0000_0200, 32'h0000_0200, 1'b0, 32'h0},          // R6
    '{32'h0000_0100, 32'h0,         32'h0000_0100, 32'h0000_0100, 1'b1, 32'h0},          // R5 edge
    '{32'h0,         32'hFFE0_0000, 32'h8020_0000, 32'h0,         1'b0, 32'h8020_0000},  // R8
    '{32'hFFFF_FFFF, 32'h8000_0000, 32'hC000_0001, 32'hC000_0001, 1'b1, 32'h8000_0000},  // R8
    '{32'hFFFF_FFFE, 32'h0,         32'h0000_01FE, 32'h0000_01FE, 1'b1, 32'h0},          // R5
    '{32'h0000_0001, 32'hFFD0_0000, 32'h0030_0000, 32'h0,         1'b0, 32'h0},          // R7
    '{32'h0,         32'h0,         32'hFFFF_FFFF, 32'h0,         1'b0, 32'h0}           // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_src(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(6'h00, v); chk("R1 status", v, 32'h0);
    rd(6'h08, v); chk("R1 enable", v, 32'h0);
    rd(6'h20, v); chk("R1 route", v, 32'h0);
    chk("R1 cascade", {31'h0, casc}, 32'h0);
    chk("R1 direct", dir, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      wr(6'h0C, 32'hFFFF_FFFF);
      wr(6'h20, VEC[i].route);
      wr(6'h08, VEC[i].en);
      drive_src(VEC[i].src);
      rd(6'h00, v); chk($sformatf("R4 vec%0d status", i), v, VEC[i].status);
      chk($sformatf("R5_R6 vec%0d cascade", i), {31'h0, casc}, {31'h0, VEC[i].casc});
      chk($sformatf("R8 vec%0d direct", i), dir, VEC[i].dir);
      rd(6'h04, v); chk($sformatf("R4 vec%0d raw", i), v, VEC[i].src);
    end

    // R7 routing readback
    wr(6'h20, 32'hFFD0_0000);
    rd(6'h20, v); chk("R7 route 0xFFD00000", v, 32'hFFC0_0000);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, v); chk("R7 route all ones", v, 32'hFFE0_0000);
    wr(6'h20, 32'h0);

    // R2 / R3 set and clear without disturbing other bits
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h08, 32'h0000_0005);
    wr(6'h08, 32'h0000_0002);
    rd(6'h08, v); chk("R2 accumulate", v, 32'h0000_0007);
    wr(6'h0C, 32'h0000_0004);
    rd(6'h08, v); chk("R3 partial clear", v, 32'h0000_0003);
    wr(6'h0C, 32'h0);
    rd(6'h08, v); chk("R3 zero clear", v, 32'h0000_0003);

    // R9 acknowledge by masking while source held
    drive_src(32'h0000_0001);
    chk("R9 cascade before ack", {31'h0, casc}, 32'h1);
    wr(6'h0C, 32'h0000_0001);
    chk("R9 cascade after ack", {31'h0, casc}, 32'h0);
    rd(6'h00, v); chk("R9 status after ack", v, 32'h0);
    rd(6'h04, v); chk("R9 raw after ack", v, 32'h0000_0001);

    // R10 unmapped and write-only offsets
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R10 enable unchanged", v, 32'h0000_0002);
    rd(6'h20, v); chk("R10 route unchanged", v, 32'h0);
    rd(6'h10, v); chk("R10 unmapped read", v, 32'h0);
    rd(6'h0C, v); chk("R10 clear offset read", v, 32'h0);

    // R1 reset mid-run
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    #1;
    rd(6'h08, v); chk("R1 enable after reset", v, 32'h0);
    rd(6'h20, v); chk("R1 route after reset", v, 32'h0);
    chk("R1 direct after reset", dir, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule